// File: doc/BRIEF.md
# Fiber Hit-Pattern Track Finder

This block looks for charged-particle track candidates inside one azimuthal sector of a layered scintillating-fiber tracker, once per bunch crossing. Each crossing presents one hit bit per fiber in every layer. A reloadable table of track equations is compared against those bits. Each equation names one fiber per layer and is satisfied when all of its named fibers fired together. Every equation carries a transverse-momentum bin tag, so a satisfied equation raises the found flag of its bin. The block also reports how many equations were satisfied.

Each sector runs its own copy of the block. Detector inefficiency is covered by loading extra equations that skip a layer. Such an equation sets the skip bit for that layer, and its result is ORed into the same bin as the full equation. The table is loaded through a simple write port while crossings keep streaming. Results leave the block a fixed two clocks after the hits enter, and a new crossing is accepted on every clock.

Top module: `fiber_track_finder`

## Requirements
- R1: While reset is asserted and after it is released, every table entry is invalid and both outputs are zero until valid entries are written.
- R2: A crossing's hit vector is sampled on a rising clock edge, and its result appears on the outputs after the second rising edge. Back-to-back crossings each produce their own result. Fiber f of layer l is bit l*16+f of `hitsIn`.
- R3: A table entry is 23 bits. Bits [4l+3:4l] hold the fiber index for layer l (l = 0..3). Bits [19:16] are the per-layer skip mask, bit 16+l for layer l. Bits [21:20] hold the bin tag, and bit 22 is the valid bit.
- R4: A layer whose skip bit is set is not examined. The entry matches whatever that layer's fibers show.
- R5: An entry whose four skip bits are all set never matches. A crossing with no hit bits gives all-zero outputs.
- R6: An entry whose valid bit is clear never matches, whatever its other fields hold.
- R7: `binFound[b]` is 1 exactly when at least one matching entry carries bin tag b. Bin 0 is the 1.5 GeV/c threshold, bin 1 is 3, bin 2 is 5 and bin 3 is 10. Several matches in one bin give a single flag.
- R8: `trackCount` is the number of matching entries, held at 2^COUNT_W-1 when the number is larger.
- R9: A write to entry `wrAddr` with `wrEn` high at a rising edge is not seen by the crossing sampled on that same edge. It is used by every crossing sampled on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| hitsIn | input | 64 | Per-layer fiber hit bits, layer-major |
| wrEn | input | 1 | Table write enable |
| wrAddr | input | 5 | Table entry to write |
| wrData | input | 23 | Entry contents, layout as in R3 |
| binFound | output | 4 | One track-found flag per momentum bin |
| trackCount | output | COUNT_W (6) | Saturating count of matching entries |

## Verification
Directed crossings come first. One hits exactly one equation's fibers. One drops a single required fiber, which separates a true match from a partial one. Others test a skipped layer, an all-skip entry and an invalid entry, which separates the mask and valid handling from the AND logic. A write is placed on the same edge as a crossing that would match the new entry, which fixes the edge at which the table change becomes visible. An all-ones crossing over a densely loaded table is checked against a narrow-counter copy of the block to expose saturation. Random crossings then mix sparse noise with the fibers of a randomly chosen entry and are interleaved with table rewrites. This tests bin ORing and counting when several entries overlap.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
  parameter int LAYERS = 4;
  parameter int FIBERS = 16;
  parameter int EQS    = 32;
  parameter int BINS   = 4;

  localparam int FIB_W     = $clog2(FIBERS);
  localparam int BIN_W     = $clog2(BINS);
  localparam int EQ_AW     = $clog2(EQS);
  localparam int HIT_W     = LAYERS * FIBERS;
  localparam int MASK_LSB  = LAYERS * FIB_W;
  localparam int BIN_LSB   = MASK_LSB + LAYERS;
  localparam int VALID_BIT = BIN_LSB + BIN_W;
  localparam int ENTRY_W   = VALID_BIT + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic           tableWe;
    logic [EQS-1:0] rowWe;
  } ftf_strobe_t;
endpackage

// File: rtl/ftf_ctrl.sv
module ftf_ctrl
  import ftf_pkg::*;
(
  input  logic             wrEn,
  input  logic [EQ_AW-1:0] wrAddr,
  output ftf_strobe_t      strobe
);
  always_comb begin
    strobe.tableWe = wrEn;
    strobe.rowWe   = '0;
    for (int r = 0; r < EQS; r++) begin
      if (wrEn && (int'(wrAddr) == r)) strobe.rowWe[r] = 1'b1;
    end
  end
endmodule

// File: rtl/ftf_eq_match.sv
module ftf_eq_match
  import ftf_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic [HIT_W-1:0]   hits,
  output logic               match
);
  logic [LAYERS-1:0] skipMask;
  logic [LAYERS-1:0] layerOk;

  assign skipMask = entry[MASK_LSB +: LAYERS];

  genvar l;
  generate
    for (l = 0; l < LAYERS; l++) begin : g_layer
      logic [FIBERS-1:0] layerHits;
      logic [FIB_W-1:0]  fiberSel;
      assign layerHits  = hits[l*FIBERS +: FIBERS];
      assign fiberSel   = entry[l*FIB_W +: FIB_W];
      assign layerOk[l] = skipMask[l] | layerHits[fiberSel];
    end
  endgenerate

  // an entry that skips every layer would fire on an empty crossing
  assign match = entry[VALID_BIT] & ~(&skipMask) & (&layerOk);
endmodule

// File: rtl/ftf_datapath.sv
module ftf_datapath
  import ftf_pkg::*;
#(
  parameter int COUNT_W = 6
)(
  input  logic               clk,
  input  logic               rstN,
  input  ftf_strobe_t        strobe,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic [HIT_W-1:0]   hitsIn,
  output logic [BINS-1:0]    binFound,
  output logic [COUNT_W-1:0] trackCount
);
  localparam int CNT_MAX = (1 << COUNT_W) - 1;

  logic [ENTRY_W-1:0] eqTable [EQS];
  logic [EQS-1:0]     matchNow;
  logic [EQS-1:0]     matchQ;
  logic [BINS-1:0]    binNow;
  logic [BINS-1:0]    binQ;
  logic [COUNT_W-1:0] countNext;

  // equation table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < EQS; r++) eqTable[r] <= '0;
    end else if (strobe.tableWe) begin
      for (int r = 0; r < EQS; r++) begin
        if (strobe.rowWe[r]) eqTable[r] <= wrData;
      end
    end
  end

  genvar r;
  generate
    for (r = 0; r < EQS; r++) begin : g_eq
      ftf_eq_match u_match (
        .entry (eqTable[r]),
        .hits  (hitsIn),
        .match (matchNow[r])
      );
    end
  endgenerate

  // bin tags are resolved in stage 1 so a write right behind a crossing cannot retag it
  always_comb begin
    binNow = '0;
    for (int e = 0; e < EQS; e++) begin
      if (matchNow[e]) binNow[eqTable[e][BIN_LSB +: BIN_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchQ <= '0;
      binQ   <= '0;
    end else begin
      matchQ <= matchNow;
      binQ   <= binNow;
    end
  end

  // stage 2: saturating population count
  always_comb begin
    int n;
    n = 0;
    for (int e = 0; e < EQS; e++) n += int'(matchQ[e]);
    if (n > CNT_MAX) n = CNT_MAX;
    countNext = COUNT_W'(n);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      binFound   <= '0;
      trackCount <= '0;
    end else begin
      binFound   <= binQ;
      trackCount <= countNext;
    end
  end
endmodule

// File: rtl/fiber_track_finder.sv
module fiber_track_finder
  import ftf_pkg::*;
#(
  parameter int COUNT_W = 6
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [HIT_W-1:0]   hitsIn,
  input  logic               wrEn,
  input  logic [EQ_AW-1:0]   wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [BINS-1:0]    binFound,
  output logic [COUNT_W-1:0] trackCount
);
  ftf_strobe_t strobe;

  ftf_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  ftf_datapath #(.COUNT_W(COUNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .hitsIn     (hitsIn),
    .binFound   (binFound),
    .trackCount (trackCount)
  );
endmodule

// File: rtl/ftf_checker.sv
module ftf_checker
  import ftf_pkg::*;
#(
  parameter int COUNT_W = 6
)(
  input logic               clk,
  input logic               rstN,
  input logic [HIT_W-1:0]   hitsIn,
  input logic               wrEn,
  input logic [BINS-1:0]    binFound,
  input logic [COUNT_W-1:0] trackCount
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5: empty crossing gives zero outputs two edges later
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && $past(hitsIn, 2) == '0) |-> (binFound == '0 && trackCount == '0));

  // R7: no bin flag without a counted match
  p_flag_needs_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (binFound != '0) |-> (trackCount != '0));

  // R7: a counted match raises at least one flag
  p_count_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trackCount != '0) |-> (binFound != '0));

  // R8: count never exceeds the table size
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(trackCount) <= EQS);

  // R2: identical back-to-back crossings with no table write give identical results
  p_repeat_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && $past(hitsIn, 1) == $past(hitsIn, 2) && !$past(wrEn, 2))
    |=> ($stable(trackCount) && $stable(binFound)));
endmodule

bind fiber_track_finder ftf_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hitsIn     (hitsIn),
  .wrEn       (wrEn),
  .binFound   (binFound),
  .trackCount (trackCount)
);

// File: tb/tb_fiber_track_finder.sv
module tb_fiber_track_finder;
  import ftf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int SAT_W      = 3;
  localparam int SAT_MAX    = (1 << SAT_W) - 1;

  logic               clk = 1'b0;
  logic               rstN;
  logic [HIT_W-1:0]   hitsIn;
  logic               wrEn;
  logic [EQ_AW-1:0]   wrAddr;
  logic [ENTRY_W-1:0] wrData;
  logic [BINS-1:0]    binFound, satBins;
  logic [CNT_W-1:0]   trackCount;
  logic [SAT_W-1:0]   satCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  fiber_track_finder #(.COUNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .hitsIn(hitsIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .binFound(binFound), .trackCount(trackCount)
  );

  fiber_track_finder #(.COUNT_W(SAT_W)) dutSat (
    .clk(clk), .rstN(rstN), .hitsIn(hitsIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .binFound(satBins), .trackCount(satCount)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [ENTRY_W-1:0] mdl [EQS];

  logic [BINS-1:0] eBinA, eBinB;
  int              eCntA, eCntB;
  string           tagA, tagB;

  function automatic logic [ENTRY_W-1:0] mkEntry(input logic [LAYERS*FIB_W-1:0] fibs,
      input logic [LAYERS-1:0] skip, input int bin, input bit valid);
    return {valid, BIN_W'(bin), skip, fibs};
  endfunction

  function automatic logic [HIT_W-1:0] hitFor(input logic [LAYERS*FIB_W-1:0] fibs);
    logic [HIT_W-1:0] h = '0;
    for (int l = 0; l < LAYERS; l++) h[l*FIBERS + int'(fibs[l*FIB_W +: FIB_W])] = 1'b1;
    return h;
  endfunction

  function automatic void calc(input logic [HIT_W-1:0] h, output logic [BINS-1:0] b, output int c);
    b = '0; c = 0;
    for (int e = 0; e < EQS; e++) begin
      logic [ENTRY_W-1:0] en = mdl[e];
      bit ok = en[VALID_BIT] && (en[MASK_LSB +: LAYERS] != '1);
      for (int l = 0; l < LAYERS; l++) begin
        if (!en[MASK_LSB + l] && !h[l*FIBERS + int'(en[l*FIB_W +: FIB_W])]) ok = 1'b0;
      end
      if (ok) begin
        c++;
        b[en[BIN_LSB +: BIN_W]] = 1'b1;
      end
    end
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; checks the crossing driven two steps earlier
  task automatic step(input logic [HIT_W-1:0] h, input bit we, input int addr,
      input logic [ENTRY_W-1:0] d, input string tag);
    logic [BINS-1:0] nb;
    int nc;
    check(tagB, "binFound", int'(binFound), int'(eBinB));
    check(tagB, "trackCount", int'(trackCount), eCntB);
    check(tagB, "sat binFound", int'(satBins), int'(eBinB));
    check(tagB, "sat trackCount R8", int'(satCount), (eCntB > SAT_MAX) ? SAT_MAX : eCntB);
    hitsIn = h;
    wrEn   = we;
    wrAddr = EQ_AW'(addr);
    wrData = d;
    calc(h, nb, nc);
    if (we) mdl[addr] = d;
    eBinB = eBinA; eCntB = eCntA; tagB = tagA;
    eBinA = nb;    eCntA = nc;    tagA = tag;
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [ENTRY_W-1:0] d, input string tag);
    step('0, 1'b1, addr, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [HIT_W-1:0] h;
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < EQS; e++) mdl[e] = '0;
    eBinA = '0; eBinB = '0; eCntA = 0; eCntB = 0; tagA = "R1"; tagB = "R1";
    rstN = 1'b0; hitsIn = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset binFound", int'(binFound), 0);
    check("R1", "reset trackCount", int'(trackCount), 0);
    rstN = 1'b1;

    // R1: empty table ignores a fully lit sector
    repeat (3) step('1, 1'b0, 0, '0, "R1");

    // R3, R2: single equation, exact and partial hits
    wr(0, mkEntry(16'h8765, 4'b0000, 1, 1'b1), "R3");
    step(hitFor(16'h8765), 1'b0, 0, '0, "R3");
    h = hitFor(16'h8765); h[2*FIBERS + 7] = 1'b0;
    step(h, 1'b0, 0, '0, "R2");
    step(hitFor(16'h8765), 1'b0, 0, '0, "R2");
    step(h, 1'b0, 0, '0, "R2");

    // R4: inefficiency equation skipping layer 2, same bin (R7 ORing)
    wr(1, mkEntry(16'h8765, 4'b0100, 1, 1'b1), "R4");
    step(h, 1'b0, 0, '0, "R4");
    step(hitFor(16'h8765), 1'b0, 0, '0, "R7");

    // R5: all-skip entry never matches
    wr(2, mkEntry(16'h0000, 4'b1111, 3, 1'b1), "R5");
    step('0, 1'b0, 0, '0, "R5");
    step('1, 1'b0, 0, '0, "R5");

    // R6: invalid entry never matches
    wr(3, mkEntry(16'h1234, 4'b0000, 2, 1'b0), "R6");
    step(hitFor(16'h1234), 1'b0, 0, '0, "R6");

    // R9: write and matching crossing on the same edge, then the next edge
    step(hitFor(16'hABCD), 1'b1, 4, mkEntry(16'hABCD, 4'b0000, 0, 1'b1), "R9");
    step(hitFor(16'hABCD), 1'b0, 0, '0, "R9");
    step(hitFor(16'hABCD) | hitFor(16'h8765), 1'b0, 0, '0, "R7");

    // R8: dense table, fully lit sector
    for (int e = 5; e < EQS; e++)
      wr(e, mkEntry(16'($urandom), 4'($urandom % 8), int'($urandom % BINS), 1'b1), "R8");
    step('1, 1'b0, 0, '0, "R8");
    step('0, 1'b0, 0, '0, "R8");
    step('1, 1'b0, 0, '0, "R8");

    // random crossings with occasional table rewrites
    for (int i = 0; i < 4000; i++) begin
      int k = int'($urandom % EQS);
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 2 == 0) h |= hitFor(mdl[k][LAYERS*FIB_W-1:0]);
      if ($urandom % 10 == 0)
        step(h, 1'b1, int'($urandom % EQS),
             mkEntry(16'($urandom), ($urandom % 4 == 0) ? 4'(1 << ($urandom % 4)) : 4'b0000,
                     int'($urandom % BINS), ($urandom % 5) != 0), "R9");
      else
        step(h, 1'b0, 0, '0, "R2");
    end
    step('0, 1'b0, 0, '0, "R5");
    step('0, 1'b0, 0, '0, "R5");
    step('0, 1'b0, 0, '0, "R5");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule